// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps outbound memory requests from a local address region onto a wider bus address space. The region is split into a row of windows that all have the same size. Each window carries its own 64-bit target base and its own enable. Software sets the window size, the window targets and a global translation switch through a simple 32-bit register port. After that, every request that presents a local address with a valid strobe gets back the translated 64-bit address, a hit flag and the index of the window that served it.

The window size is a power of two in megabytes and is programmed as its exponent. A window's enable sits in bit 0 of the low word of its target base. Because windows are at least 1 MB, the low target bits play no part in the translated address. The usual way to use the block is to fill windows 0, 1, 2 and so on in order until the region is covered, then switch translation on. The control register also holds an independent link-enable bit that translation changes never touch.

Responses come from a two-state response stage. State `RSP_EMPTY` means no result is pending. State `RSP_FULL` means a result is presented. The transitions are:
- FILL (`RSP_EMPTY` to `RSP_FULL`) on a request.
- REFILL (`RSP_FULL` to `RSP_FULL`) on a back-to-back request.
- DRAIN (`RSP_FULL` to `RSP_EMPTY`) when no request arrives.
- IDLE (`RSP_EMPTY` to `RSP_EMPTY`) when there is still no request.

Top module: `otw_xlate`

## Requirements
- R1: After reset the response valid is low, and the control, size and all window registers read 0. Translation is therefore off and every window is disabled.
- R2: The register map is as follows, and every register reads back what was written to it:
  - The low word of window n is at byte offset 0x200 + 8·n and the high word at 0x204 + 8·n. Both read back the full 32 bits.
  - The size register is at 0x030 and holds a 3-bit exponent e in bits 2:0. The window size is 2^e MB.
  - The control register is at 0x004, with link enable in bit 0 and translation enable in bit 1.
- R3: The link-enable and translation-enable bits are stored independently. Changing one of them through a read-modify-write leaves the other one as read back.
- R4: A request in cycle k is answered with response valid in cycle k+1. Response valid is low in any cycle that follows a cycle with no request, and the response outputs hold their values while no request arrives.
- R5: The window index is (local address − region base) >> (20 + e). On a hit, the translated address is the window's 64-bit target base (high:low) with its low 20+e bits replaced by the offset within the window. The reported index is the window index.
- R6: A request whose window index is NUM_WIN or more misses. An address below the region base wraps to a large offset and also misses. A miss returns hit low, index 0 and the local address zero-extended to 64 bits.
- R7: A request that falls in a window whose bit 0 (enable) is clear misses, with the same outputs as in R6.
- R8: While the translation enable is clear, every request misses, with the same outputs as in R6.
- R9: Target base bits below the window size are ignored, including the enable bit.
- R10: A new size exponent takes effect for requests in the cycles after the write. This changes both the window selected and the offset kept.
- R11: Writes to offsets that map to no register have no effect. This includes the slot of a window beyond NUM_WIN. Such offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | LOC_AW | Local request address |
| resp_valid | output | 1 | Result presented |
| resp_hit | output | 1 | Request fell in an enabled window with translation on |
| resp_idx | output | IDX_W | Window index on a hit, 0 on a miss |
| resp_addr | output | 64 | Translated address, or the zero-extended local address on a miss |

## Verification
The bench goes after the edges of each window and the last byte before the region ends. A design with an off-by-one range compare would translate the first address past the last window instead of passing it through. It probes addresses below the region base, where a signed or unwrapped subtraction would select window 0. It programs target bases with junk in their low bits, including the enable bit, which would leak into the output if masking were missing. It switches the size exponent at run time, which exposes a shift fixed at 8 MB, and pairs a translation-enable write with the link bit to catch a control write that clears its neighbour.

// File: rtl/otw_pkg.sv
package otw_pkg;

    localparam int RA_W     = 12;
    localparam int MB_SHIFT = 20;

    localparam logic [RA_W-1:0] OFS_CTRL     = 12'h004;
    localparam logic [RA_W-1:0] OFS_WSIZE    = 12'h030;
    localparam logic [RA_W-1:0] OFS_WIN_BASE = 12'h200;
    localparam logic [RA_W-1:0] WIN_STRIDE   = 12'h008;
    localparam logic [RA_W-1:0] HI_WORD_OFS  = 12'h004;

    typedef struct packed {
        logic xlat_en;
        logic link_en;
    } ctrl_t;

    typedef enum logic {
        RSP_EMPTY = 1'b0,
        RSP_FULL  = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/otw_regs.sv
module otw_regs
    import otw_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int EXP_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [RA_W-1:0]           reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output ctrl_t                     ctrl_q,
    output logic [EXP_W-1:0]          size_exp_q,
    output logic [NUM_WIN-1:0][31:0]  win_lo_q,
    output logic [NUM_WIN-1:0][31:0]  win_hi_q
);

    logic [NUM_WIN-1:0] sel_lo;
    logic [NUM_WIN-1:0] sel_hi;
    logic               sel_ctrl;
    logic               sel_size;
    logic [31:0]        rd_mux;

    assign sel_ctrl = (reg_addr == OFS_CTRL);
    assign sel_size = (reg_addr == OFS_WSIZE);

    generate
        for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
            localparam logic [RA_W-1:0] LO_OFS = OFS_WIN_BASE + RA_W'(n) * WIN_STRIDE;

            assign sel_lo[n] = (reg_addr == LO_OFS);
            assign sel_hi[n] = (reg_addr == LO_OFS + HI_WORD_OFS);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    win_lo_q[n] <= '0;
                    win_hi_q[n] <= '0;
                end else if (reg_wr) begin
                    if (sel_lo[n]) win_lo_q[n] <= reg_wdata;
                    if (sel_hi[n]) win_hi_q[n] <= reg_wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            size_exp_q <= '0;
        end else if (reg_wr) begin
            if (sel_ctrl) ctrl_q     <= ctrl_t'(reg_wdata[1:0]);
            if (sel_size) size_exp_q <= reg_wdata[EXP_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel_ctrl) rd_mux = {30'b0, ctrl_q};
        if (sel_size) rd_mux = {{(32-EXP_W){1'b0}}, size_exp_q};
        for (int n = 0; n < NUM_WIN; n++) begin
            if (sel_lo[n]) rd_mux = win_lo_q[n];
            if (sel_hi[n]) rd_mux = win_hi_q[n];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

endmodule

// File: rtl/otw_lookup.sv
module otw_lookup
    import otw_pkg::*;
#(
    parameter int              NUM_WIN     = 8,
    parameter int              EXP_W       = 3,
    parameter int              LOC_AW      = 32,
    parameter logic [LOC_AW-1:0] REGION_BASE = '0,
    parameter int              IDX_W       = 3
) (
    input  logic [LOC_AW-1:0]          loc_addr,
    input  ctrl_t                      ctrl,
    input  logic [EXP_W-1:0]           size_exp,
    input  logic [NUM_WIN-1:0][31:0]   win_lo,
    input  logic [NUM_WIN-1:0][31:0]   win_hi,
    output logic                       hit,
    output logic [IDX_W-1:0]           idx,
    output logic [63:0]                xaddr
);

    localparam int SH_W = 6;

    logic [LOC_AW-1:0] offset;
    logic [SH_W-1:0]   shamt;
    logic [LOC_AW-1:0] raw_idx;
    logic              in_range;
    logic [IDX_W-1:0]  sel;
    logic [63:0]       tgt_base;
    logic              win_en;
    logic [63:0]       keep_mask;
    logic [63:0]       offset64;

    assign offset   = loc_addr - REGION_BASE;
    assign shamt    = SH_W'(MB_SHIFT) + SH_W'(size_exp);
    assign raw_idx  = offset >> shamt;
    assign in_range = (raw_idx < LOC_AW'(NUM_WIN));
    assign sel      = raw_idx[IDX_W-1:0];
    assign offset64 = {{(64-LOC_AW){1'b0}}, offset};
    assign keep_mask = (64'd1 << shamt) - 64'd1;

    always_comb begin
        tgt_base = '0;
        win_en   = 1'b0;
        for (int n = 0; n < NUM_WIN; n++) begin
            if (sel == IDX_W'(n)) begin
                tgt_base = {win_hi[n], win_lo[n]};
                win_en   = win_lo[n][0];
            end
        end
    end

    assign hit   = ctrl.xlat_en && in_range && win_en;
    assign idx   = hit ? sel : '0;
    assign xaddr = hit ? ((tgt_base & ~keep_mask) | (offset64 & keep_mask))
                       : {{(64-LOC_AW){1'b0}}, loc_addr};

endmodule

// File: rtl/otw_resp.sv
module otw_resp
    import otw_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             lk_hit,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [63:0]      lk_addr,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic [IDX_W-1:0] resp_idx,
    output logic [63:0]      resp_addr
);

    rsp_state_e state_q;
    rsp_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_EMPTY: state_d = req_valid ? RSP_FULL : RSP_EMPTY;  // FILL / IDLE
            RSP_FULL:  state_d = req_valid ? RSP_FULL : RSP_EMPTY;  // REFILL / DRAIN
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_hit  <= 1'b0;
            resp_idx  <= '0;
            resp_addr <= '0;
        end else if (req_valid) begin
            resp_hit  <= lk_hit;
            resp_idx  <= lk_idx;
            resp_addr <= lk_addr;
        end
    end

    assign resp_valid = (state_q == RSP_FULL);

endmodule

// File: rtl/otw_xlate.sv
module otw_xlate
    import otw_pkg::*;
#(
    parameter int                NUM_WIN     = 8,
    parameter int                EXP_W       = 3,
    parameter int                LOC_AW      = 32,
    parameter logic [LOC_AW-1:0] REGION_BASE = 32'h5000_0000,
    localparam int               IDX_W       = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    input  logic [LOC_AW-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [IDX_W-1:0]  resp_idx,
    output logic [63:0]       resp_addr
);

    ctrl_t                     ctrl_q;
    logic [EXP_W-1:0]          size_exp_q;
    logic [NUM_WIN-1:0][31:0]  win_lo_q;
    logic [NUM_WIN-1:0][31:0]  win_hi_q;
    logic                      lk_hit;
    logic [IDX_W-1:0]          lk_idx;
    logic [63:0]               lk_addr;

    otw_regs #(.NUM_WIN(NUM_WIN), .EXP_W(EXP_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ctrl_q     (ctrl_q),
        .size_exp_q (size_exp_q),
        .win_lo_q   (win_lo_q),
        .win_hi_q   (win_hi_q)
    );

    otw_lookup #(
        .NUM_WIN(NUM_WIN), .EXP_W(EXP_W), .LOC_AW(LOC_AW),
        .REGION_BASE(REGION_BASE), .IDX_W(IDX_W)
    ) u_lookup (
        .loc_addr (req_addr),
        .ctrl     (ctrl_q),
        .size_exp (size_exp_q),
        .win_lo   (win_lo_q),
        .win_hi   (win_hi_q),
        .hit      (lk_hit),
        .idx      (lk_idx),
        .xaddr    (lk_addr)
    );

    otw_resp #(.IDX_W(IDX_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .lk_hit     (lk_hit),
        .lk_idx     (lk_idx),
        .lk_addr    (lk_addr),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_idx   (resp_idx),
        .resp_addr  (resp_addr)
    );

endmodule

// File: rtl/otw_xlate_chk.sv
module otw_xlate_chk #(
    parameter int                LOC_AW      = 32,
    parameter int                IDX_W       = 3,
    parameter logic [LOC_AW-1:0] REGION_BASE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LOC_AW-1:0] req_addr,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic [IDX_W-1:0]  resp_idx,
    input logic [63:0]       resp_addr,
    input logic              xlat_en
);

    logic [LOC_AW-1:0] req_off;
    logic [63:0]       req_zext;

    assign req_off  = req_addr - REGION_BASE;
    assign req_zext = {{(64-LOC_AW){1'b0}}, req_addr};

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);  // R4

    AST_NO_RESP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);  // R4

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(resp_addr) && $stable(resp_hit));  // R4

    AST_MISS_PASSES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (resp_hit || resp_addr == $past(req_zext)));  // R6

    AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_idx == '0));  // R6

    AST_XLAT_OFF_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlat_en) |=> !resp_hit);  // R8

    AST_OFFSET_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!resp_hit || resp_addr[19:0] == $past(req_off[19:0])));  // R5

endmodule

bind otw_xlate otw_xlate_chk #(
    .LOC_AW(LOC_AW), .IDX_W(IDX_W), .REGION_BASE(REGION_BASE)
) u_otw_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_idx   (resp_idx),
    .resp_addr  (resp_addr),
    .xlat_en    (ctrl_q.xlat_en)
);

// File: tb/test_otw_xlate.sv
module test_otw_xlate;

    localparam int          NW   = 8;
    localparam logic [31:0] BASE = 32'h5000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        resp_valid;
    logic        resp_hit;
    logic [2:0]  resp_idx;
    logic [63:0] resp_addr;

    otw_xlate i_otw_xlate (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_idx(resp_idx), .resp_addr(resp_addr)
    );

    always #10 clk = ~clk;

    // behavioural reference state
    logic [31:0] m_lo [NW];
    logic [31:0] m_hi [NW];
    int          m_exp;
    bit          m_link, m_xlat;

    bit          e_valid = 0, e_hit = 0, e_rd = 0;
    int          e_idx = 0;
    logic [63:0] e_addr = '0;
    logic [31:0] e_rdata = '0;

    int    checks = 0, errors = 0, cyc = 0;
    bit    done = 0;
    string cur_req = "R1";

    function automatic logic [31:0] model_read(logic [11:0] a);
        if (a == 12'h004) return {30'b0, m_xlat, m_link};
        if (a == 12'h030) return 32'(m_exp);
        for (int n = 0; n < NW; n++) begin
            if (a == 12'h200 + 12'(8*n)) return m_lo[n];
            if (a == 12'h204 + 12'(8*n)) return m_hi[n];
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NW; n++) begin m_lo[n] = 0; m_hi[n] = 0; end
            m_exp = 0; m_link = 0; m_xlat = 0;
            e_valid = 0; e_rd = 0;
        end else begin
            e_valid = req_valid;
            if (req_valid) begin
                longint unsigned off, idx, mask, tb;
                off  = longint'(req_addr - BASE) & 64'hFFFF_FFFF;
                mask = (64'd1 << (20 + m_exp)) - 1;
                idx  = off >> (20 + m_exp);
                e_hit = m_xlat && idx < NW && m_lo[idx % NW][0];
                if (e_hit) begin
                    tb     = {m_hi[idx], m_lo[idx]};
                    e_idx  = int'(idx);
                    e_addr = (tb & ~mask) | (off & mask);
                end else begin
                    e_idx  = 0;
                    e_addr = {32'b0, req_addr};
                end
            end
            e_rd = reg_rd;
            if (reg_rd) e_rdata = model_read(reg_addr);
            if (reg_wr) begin
                if (reg_addr == 12'h004) begin m_link = reg_wdata[0]; m_xlat = reg_wdata[1]; end
                if (reg_addr == 12'h030) m_exp = int'(reg_wdata[2:0]);
                for (int n = 0; n < NW; n++) begin
                    if (reg_addr == 12'h200 + 12'(8*n)) m_lo[n] = reg_wdata;
                    if (reg_addr == 12'h204 + 12'(8*n)) m_hi[n] = reg_wdata;
                end
            end
        end
    end

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("resp_valid", 64'(resp_valid), 64'(e_valid));
            if (e_valid) begin
                chk("resp_hit", 64'(resp_hit), 64'(e_hit));
                chk("resp_idx", 64'(resp_idx), 64'(e_idx));
                chk("resp_addr", resp_addr, e_addr);
            end
            if (e_rd) chk("reg_rdata", 64'(reg_rdata), 64'(e_rdata));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            reg_wr = 0; reg_rd = 0; req_valid = 0;
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_rd = 0; req_valid = 0;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic rd(logic [11:0] a);
        @(negedge clk);
        reg_wr = 0; req_valid = 0;
        reg_rd = 1; reg_addr = a;
    endtask

    task automatic req(logic [31:0] a);
        @(negedge clk);
        reg_wr = 0; reg_rd = 0;
        req_valid = 1; req_addr = a;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(4);
        rst_n = 1;
        idle(1);
        rd(12'h004); rd(12'h030); rd(12'h200); rd(12'h23C);
        req(BASE);
        idle(2);

        // R2: register map and readback
        cur_req = "R2";
        for (int n = 0; n < NW; n++) begin
            wr(12'h200 + 12'(8*n), 32'h8000_0000 + 32'(n) * 32'h0100_0000 + 32'h0001_2341);
            wr(12'h204 + 12'(8*n), 32'h0000_0010 + 32'(n));
        end
        wr(12'h030, 32'hFFFF_FFFB);
        for (int n = 0; n < NW; n++) begin
            rd(12'h200 + 12'(8*n)); rd(12'h204 + 12'(8*n));
        end
        rd(12'h030);
        idle(1);

        // R3: link and translation enables are independent
        cur_req = "R3";
        wr(12'h004, 32'h1); rd(12'h004);
        wr(12'h004, 32'h3); rd(12'h004);
        wr(12'h004, 32'h2); rd(12'h004);
        wr(12'h004, 32'h0); rd(12'h004);
        idle(1);

        // R8: translation off, windows enabled
        cur_req = "R8";
        wr(12'h004, 32'h1);
        req(BASE); req(BASE + 32'h0080_0010); req(BASE + 32'h0123_4567);
        idle(1);

        // R5: hits in every window, size 8 MB
        cur_req = "R5";
        wr(12'h030, 32'h3);
        wr(12'h004, 32'h3);
        rd(12'h004);
        for (int n = 0; n < NW; n++) begin
            req(BASE + 32'(n) * 32'h0080_0000);
            req(BASE + 32'(n) * 32'h0080_0000 + 32'h0007_FFFF - 32'(n));
        end
        req(BASE + 32'h0400_0000 - 1);
        idle(1);

        // R9: junk low target bits must not leak
        cur_req = "R9";
        wr(12'h210, 32'hFFFF_FFFF);
        wr(12'h214, 32'hA5A5_A5A5);
        req(BASE + 32'h0100_0000); req(BASE + 32'h017F_FFFF);
        idle(1);

        // R6: out of range above and below
        cur_req = "R6";
        req(BASE + 32'h0400_0000); req(BASE - 1); req(32'h0000_0000); req(32'hFFFF_FFFF);
        idle(1);

        // R7: disabled window
        cur_req = "R7";
        wr(12'h228, 32'h8500_0000);
        req(BASE + 32'h0280_0040); req(BASE + 32'h0300_0040);
        idle(1);

        // R10: size changes
        cur_req = "R10";
        wr(12'h030, 32'h0);
        req(BASE + 32'h0010_0000); req(BASE + 32'h0070_0001); req(BASE + 32'h0080_0000);
        wr(12'h030, 32'h2);
        req(BASE + 32'h0040_0004); req(BASE + 32'h01FF_FFFF); req(BASE + 32'h0200_0000);
        idle(1);

        // R4: back-to-back and gaps
        cur_req = "R4";
        wr(12'h030, 32'h3);
        req(BASE + 32'h0000_1000); req(BASE + 32'h0080_2000); idle(2);
        req(BASE + 32'h0100_3000); idle(1); req(BASE - 32'h10); idle(3);

        // R11: unmapped writes ignored
        cur_req = "R11";
        wr(12'h240, 32'hFFFF_FFFF); wr(12'h244, 32'h1234_5678);
        wr(12'h100, 32'hFFFF_FFFF); wr(12'h008, 32'hFFFF_FFFF);
        rd(12'h240); rd(12'h244); rd(12'h100); rd(12'h008);
        rd(12'h200); rd(12'h004); rd(12'h030);
        req(BASE + 32'h0000_0010); req(BASE + 32'h0400_0010);
        idle(3);

        finish_run();
    end

endmodule